// File: doc/BRIEF.md
# Strobe Delay Tap Calibrator

This block decides how many fabric delay elements sit in the read-strobe path, so that the delayed strobe lands inside the window where read data is valid. A replica chain, built exactly like the strobe delay line and routed the same way, oscillates freely. Its edges are counted over a fixed reference window outside this block. Each finished count arrives on `measCount` with a one-cycle `measValid` pulse. The block scales the count into a candidate number of taps and clamps it to a legal range. It then compares the candidate with the tap setting now in use.

A change is not taken at once. The candidate must lie outside a hysteresis band around the current setting. The band has separate up and down widths. The same direction of change must then be requested by a set number of measurements in a row. A qualified change is held as pending. The strobe-delay select lines move only in a cycle where the read path reports that no data is arriving. That commit is marked by a one-cycle done pulse.

Calibration runs all the time. As the die warms and the elements slow down, the count falls and the setting follows. The setting never changes while a capture is in progress.

Top module: `strobe_tap_cal`

## Requirements
- R1: After reset, `tapSel` equals TAP_RESET (default 12), no change is pending, the run count is zero and `updDone` is 0.
- R2: A measurement gives the candidate floor(measCount * TAP_MULT / 2^TAP_SHIFT), clamped to TAP_MIN..TAP_MAX. The defaults are 3, 4, 2 and 24, so a count of 1023 gives 24 and a count of 0 gives 2.
- R3: A measurement requests an increase only when candidate > tapSel + HYST_UP (default 1).
- R4: A measurement requests a decrease only when candidate + HYST_DN < tapSel (default 2).
- R5: A measurement whose candidate lies inside the hysteresis band clears the consecutive-run count.
- R6: A change qualifies only after RUN_LEN (default 3) consecutive measurements request the same direction. The pending value is the candidate of the last of them.
- R7: A measurement that requests the direction opposite to the current run restarts the run at one, in the new direction.
- R8: While a change is pending and `readIdle` is low, `tapSel` keeps its value.
- R9: At the first clock edge where a change is pending and `readIdle` is high, `tapSel` takes the pending value, and `updDone` is high for exactly the next cycle.
- R10: Measurements that arrive while a change is pending have no effect. The committed value is the one that qualified, and a new run starts from zero after the commit.
- R11: Over a series of drifting counts, the setting keeps following the measurements, with every change committed through R3 to R9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock |
| rstN | input | 1 | Asynchronous active-low reset |
| measValid | input | 1 | One-cycle strobe: a new replica count is on measCount |
| measCount | input | CNT_W | Replica oscillation count over the reference window |
| readIdle | input | 1 | High when no read data is arriving; tap updates allowed |
| tapSel | output | TAP_W | Number of delay elements selected in the strobe path |
| updDone | output | 1 | One-cycle pulse after a new tap value is committed |

## Verification
On every cycle, the embedded properties check the following:
- the setting never moves except in an idle cycle, and only together with the done pulse;
- every committed change clears the hysteresis margin in its direction;
- a pending change survives busy cycles;
- the run counter stays below its limit and is held at zero while a change is pending.

Other behaviour can only be shown by the bench's scenarios. This covers the arithmetic of count-to-tap scaling and clamping, and the exact band edges, where a candidate one tap short of the margin must be held. It also covers a run broken by an in-band or reversed measurement, and a pending value that later measurements must not overwrite.

// File: rtl/strobe_cal_pkg.sv
package strobe_cal_pkg;

  // Direction requested by one measurement against the current tap setting
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } stepDir_e;

  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic latchPend;  // capture the current candidate as the pending tap
    logic commitTap;  // move the pending tap onto the select lines
  } calStrobes_t;

endpackage

// File: rtl/strobe_cal_datapath.sv
module strobe_cal_datapath
  import strobe_cal_pkg::*;
#(
  parameter int CNT_W     = 10,
  parameter int TAP_W     = 5,
  parameter int TAP_MIN   = 2,
  parameter int TAP_MAX   = 24,
  parameter int TAP_RESET = 12,
  parameter int TAP_MULT  = 3,
  parameter int TAP_SHIFT = 4,
  parameter int HYST_UP   = 1,
  parameter int HYST_DN   = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] measCount,
  input  calStrobes_t      ctrl,
  output stepDir_e         stepDir,
  output logic [TAP_W-1:0] tapSel
);

  localparam int MULT_W = $clog2(TAP_MULT + 1);
  localparam int PROD_W = CNT_W + MULT_W;
  localparam int HW     = TAP_W + 2;

  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] scaled;
  logic [TAP_W-1:0]  cand;
  logic [TAP_W-1:0]  pendTap;
  logic [HW-1:0]     candW;
  logic [HW-1:0]     tapW;

  // Replica count to tap count: a faster element gives more oscillations,
  // so more elements are needed for the same target delay.
  assign prod = PROD_W'(measCount) * PROD_W'(TAP_MULT);

  generate
    if (TAP_SHIFT == 0) begin : g_noShift
      assign scaled = prod;
    end else begin : g_shift
      assign scaled = prod >> TAP_SHIFT;
    end
  endgenerate

  always_comb begin
    if (scaled < PROD_W'(TAP_MIN))      cand = TAP_W'(TAP_MIN);
    else if (scaled > PROD_W'(TAP_MAX)) cand = TAP_W'(TAP_MAX);
    else                                cand = scaled[TAP_W-1:0];
  end

  // Hysteresis band around the committed setting
  assign candW = HW'(cand);
  assign tapW  = HW'(tapSel);

  always_comb begin
    if (candW > tapW + HW'(HYST_UP))       stepDir = STEP_UP;
    else if (candW + HW'(HYST_DN) < tapW)  stepDir = STEP_DOWN;
    else                                   stepDir = STEP_HOLD;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendTap <= TAP_W'(TAP_RESET);
      tapSel  <= TAP_W'(TAP_RESET);
    end else begin
      if (ctrl.latchPend) pendTap <= cand;
      if (ctrl.commitTap) tapSel  <= pendTap;
    end
  end

  // The committed setting stays inside the clamp range (R2)
  assert_tap_in_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    (int'(tapSel) >= TAP_MIN) && (int'(tapSel) <= TAP_MAX));

  // The pending tap is not overwritten while it is being committed (R10)
  assert_no_latch_on_commit_R10: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.commitTap |-> !ctrl.latchPend);

endmodule

// File: rtl/strobe_cal_ctrl.sv
module strobe_cal_ctrl
  import strobe_cal_pkg::*;
#(
  parameter int RUN_LEN = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        measValid,
  input  logic        readIdle,
  input  stepDir_e    stepDir,
  output calStrobes_t strobes,
  output logic        updDone
);

  localparam int RUN_W = $clog2(RUN_LEN + 1);

  logic [RUN_W-1:0] runCnt;
  logic [RUN_W-1:0] nextRun;
  stepDir_e         runDir;
  logic             pending;
  logic             measTake;
  logic             sameRun;
  logic             qualify;

  // Measurements are discarded while a change waits for an idle gap
  assign measTake = measValid && !pending;
  assign sameRun  = (stepDir == runDir) && (runCnt != '0);
  assign nextRun  = sameRun ? runCnt + RUN_W'(1) : RUN_W'(1);
  assign qualify  = measTake && (stepDir != STEP_HOLD) && (nextRun >= RUN_W'(RUN_LEN));

  assign strobes.latchPend = qualify;
  assign strobes.commitTap = pending && readIdle;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt  <= '0;
      runDir  <= STEP_HOLD;
      pending <= 1'b0;
      updDone <= 1'b0;
    end else begin
      updDone <= strobes.commitTap;
      if (strobes.commitTap)  pending <= 1'b0;
      else if (qualify)       pending <= 1'b1;
      if (measTake) begin
        if (stepDir == STEP_HOLD) begin
          runCnt <= '0;
          runDir <= STEP_HOLD;
        end else if (qualify) begin
          runCnt <= '0;
          runDir <= STEP_HOLD;
        end else begin
          runCnt <= nextRun;
          runDir <= stepDir;
        end
      end
    end
  end

  // A pending change survives every busy cycle (R8)
  assert_pend_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (pending && !readIdle) |=> pending);

  // The run counter never reaches the qualifying length as stored state (R6)
  assert_run_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    int'(runCnt) < RUN_LEN);

  // An in-band measurement clears the run (R5)
  assert_hold_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    (measTake && stepDir == STEP_HOLD) |=> (runCnt == '0));

  // No run is built while a change is pending (R10)
  assert_pend_no_run_R10: assert property (@(posedge clk) disable iff (!rstN)
    pending |-> (runCnt == '0));

  // The done flag is a single-cycle pulse (R9)
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    updDone |=> !updDone);

endmodule

// File: rtl/strobe_tap_cal.sv
module strobe_tap_cal
  import strobe_cal_pkg::*;
#(
  parameter int CNT_W     = 10,
  parameter int TAP_W     = 5,
  parameter int TAP_MIN   = 2,
  parameter int TAP_MAX   = 24,
  parameter int TAP_RESET = 12,
  parameter int TAP_MULT  = 3,
  parameter int TAP_SHIFT = 4,
  parameter int HYST_UP   = 1,
  parameter int HYST_DN   = 2,
  parameter int RUN_LEN   = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             measValid,
  input  logic [CNT_W-1:0] measCount,
  input  logic             readIdle,
  output logic [TAP_W-1:0] tapSel,
  output logic             updDone
);

  stepDir_e    stepDir;
  calStrobes_t strobes;

  strobe_cal_datapath #(
    .CNT_W(CNT_W), .TAP_W(TAP_W), .TAP_MIN(TAP_MIN), .TAP_MAX(TAP_MAX),
    .TAP_RESET(TAP_RESET), .TAP_MULT(TAP_MULT), .TAP_SHIFT(TAP_SHIFT),
    .HYST_UP(HYST_UP), .HYST_DN(HYST_DN)
  ) datapath_i (
    .clk(clk), .rstN(rstN), .measCount(measCount), .ctrl(strobes),
    .stepDir(stepDir), .tapSel(tapSel)
  );

  strobe_cal_ctrl #(
    .RUN_LEN(RUN_LEN)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .measValid(measValid), .readIdle(readIdle),
    .stepDir(stepDir), .strobes(strobes), .updDone(updDone)
  );

  // Select lines move only after an idle cycle (R8)
  assert_tap_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(tapSel) |-> $past(readIdle));

  // Every change of the select lines is flagged by the done pulse (R9)
  assert_tap_change_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(tapSel) |-> updDone);

  // An upward commit clears the upper margin (R3)
  assert_hyst_up_R3: assert property (@(posedge clk) disable iff (!rstN)
    (updDone && tapSel > $past(tapSel)) |->
      (int'(tapSel) > int'($past(tapSel)) + HYST_UP));

  // A downward commit clears the lower margin (R4)
  assert_hyst_dn_R4: assert property (@(posedge clk) disable iff (!rstN)
    (updDone && tapSel < $past(tapSel)) |->
      (int'(tapSel) + HYST_DN < int'($past(tapSel))));

endmodule

// File: tb/strobe_tap_cal_tb.sv
`timescale 1ns/1ps
module strobe_tap_cal_tb_top;

  localparam int CNT_W     = 10;
  localparam int TAP_W     = 5;
  localparam int TAP_MIN   = 2;
  localparam int TAP_MAX   = 24;
  localparam int TAP_RESET = 12;
  localparam int TAP_MULT  = 3;
  localparam int TAP_SHIFT = 4;
  localparam int HYST_UP   = 1;
  localparam int HYST_DN   = 2;
  localparam int RUN_LEN   = 3;

  logic             clk = 1'b0;
  logic             rstN;
  logic             measValid;
  logic [CNT_W-1:0] measCount;
  logic             readIdle;
  logic [TAP_W-1:0] tapSel;
  logic             updDone;

  int checks = 0;
  int fails  = 0;
  string curReq = "R1";

  // Reference model state
  int mTap, mPendTap, mRun, mRunDir;
  bit mPend, mDone;

  always #2 clk = ~clk;

  strobe_tap_cal #(
    .CNT_W(CNT_W), .TAP_W(TAP_W), .TAP_MIN(TAP_MIN), .TAP_MAX(TAP_MAX),
    .TAP_RESET(TAP_RESET), .TAP_MULT(TAP_MULT), .TAP_SHIFT(TAP_SHIFT),
    .HYST_UP(HYST_UP), .HYST_DN(HYST_DN), .RUN_LEN(RUN_LEN)
  ) dut_i (
    .clk(clk), .rstN(rstN), .measValid(measValid), .measCount(measCount),
    .readIdle(readIdle), .tapSel(tapSel), .updDone(updDone)
  );

  function automatic int candOf(int cnt);
    int c;
    c = (cnt * TAP_MULT) / (1 << TAP_SHIFT);
    if (c < TAP_MIN) c = TAP_MIN;
    if (c > TAP_MAX) c = TAP_MAX;
    return c;
  endfunction

  function automatic int dirOf(int c, int tap);
    if (c > tap + HYST_UP) return 1;
    if (c + HYST_DN < tap) return 2;
    return 0;
  endfunction

  task automatic compare();
    checks++;
    if (int'(tapSel) != mTap) begin
      fails++;
      $display("FAIL %s tapSel actual %0d expected %0d", curReq, tapSel, mTap);
    end
    checks++;
    if (updDone != mDone) begin
      fails++;
      $display("FAIL %s updDone actual %0b expected %0b", curReq, updDone, mDone);
    end
  endtask

  // Called at a falling edge: drive, advance one clock, update model, compare
  task automatic cycle(bit v, int cnt, bit idle);
    bit oldPend;
    int c, d, n;
    measValid = v;
    measCount = CNT_W'(cnt);
    readIdle  = idle;
    @(posedge clk);
    oldPend = mPend;
    mDone = 1'b0;
    if (oldPend && idle) begin
      mTap  = mPendTap;
      mPend = 1'b0;
      mDone = 1'b1;
    end
    if (v && !oldPend) begin
      c = candOf(cnt);
      d = dirOf(c, mTap);
      if (d == 0) begin
        mRun = 0; mRunDir = 0;
      end else begin
        n = (d == mRunDir && mRun != 0) ? mRun + 1 : 1;
        if (n >= RUN_LEN) begin
          mPend = 1'b1; mPendTap = c; mRun = 0; mRunDir = 0;
        end else begin
          mRun = n; mRunDir = d;
        end
      end
    end
    @(negedge clk);
    compare();
  endtask

  task automatic meas(int cnt, bit idle);
    cycle(1'b1, cnt, idle);
  endtask

  task automatic idleCycles(int n, bit idle);
    for (int i = 0; i < n; i++) cycle(1'b0, 0, idle);
  endtask

  initial begin
    void'($urandom(32'd4242));
    rstN = 1'b0; measValid = 1'b0; measCount = '0; readIdle = 1'b0;
    mTap = TAP_RESET; mPendTap = TAP_RESET; mRun = 0; mRunDir = 0;
    mPend = 1'b0; mDone = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    curReq = "R1";
    compare();
    idleCycles(2, 1'b1);

    // R6/R8/R9: three counts of 107 (candidate 20) qualify; held while busy
    curReq = "R6";
    meas(107, 1'b0); meas(107, 1'b0); meas(107, 1'b0);
    curReq = "R8";
    idleCycles(4, 1'b0);
    curReq = "R9";
    idleCycles(3, 1'b1);

    // R3: tap 20, candidate 21 sits on the band edge, 22 moves up
    curReq = "R3";
    meas(112, 1'b1); meas(112, 1'b1); meas(112, 1'b1);
    meas(118, 1'b1); meas(118, 1'b1); meas(118, 1'b1);
    idleCycles(3, 1'b1);

    // R4: tap 22, candidate 20 is held, 19 moves down
    curReq = "R4";
    meas(107, 1'b1); meas(107, 1'b1); meas(107, 1'b1);
    meas(102, 1'b1); meas(102, 1'b1); meas(102, 1'b1);
    idleCycles(3, 1'b1);

    // R5: an in-band count between two up requests breaks the run
    curReq = "R5";
    meas(150, 1'b0); meas(150, 1'b0); meas(102, 1'b0);
    meas(150, 1'b0); meas(150, 1'b0);
    idleCycles(3, 1'b1);

    // R7: a reversal restarts the run in the new direction
    curReq = "R7";
    meas(150, 1'b0); meas(150, 1'b0); meas(40, 1'b0);
    meas(40, 1'b0); meas(150, 1'b0); meas(150, 1'b0);
    idleCycles(3, 1'b1);

    // R2: clamp at both ends
    curReq = "R2";
    meas(1023, 1'b1); meas(1023, 1'b1); meas(1023, 1'b1);
    idleCycles(3, 1'b1);
    meas(0, 1'b1); meas(0, 1'b1); meas(0, 1'b1);
    idleCycles(3, 1'b1);

    // R10: measurements during a pending change are ignored
    curReq = "R10";
    meas(107, 1'b0); meas(107, 1'b0); meas(107, 1'b0);
    meas(1023, 1'b0); meas(1023, 1'b0); meas(0, 1'b0);
    idleCycles(2, 1'b1);
    meas(0, 1'b1); meas(0, 1'b1);
    idleCycles(3, 1'b1);

    // R11: random drift with random read activity
    curReq = "R11";
    for (int i = 0; i < 4000; i++) begin
      cycle(($urandom % 3) == 0, 40 + int'($urandom % 120), ($urandom % 2) == 0);
    end
    idleCycles(4, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule